// File: doc/BRIEF.md
# MII Management Status Poller

This block keeps an eye on the link of the attached Ethernet PHY without software having to act. While polling is enabled and a PHY is marked active, it runs standard clause-22 management read frames on its own MDC/MDIO pins. Each frame reads one PHY register, normally register 1, the basic status register. A programmable idle gap separates the frames. Software supplies the PHY and register addresses, and it sets the gap through a 3-bit code.

Each 16-bit word that comes back is compared with the word from the previous poll. If the link-status bit falls from 1 to 0, the block sets a sticky link-lost flag. If any bit of the word differs, it sets a sticky changed flag. Either flag drives the interrupt line. Software clears a flag by pulsing a 1 on that flag's clear bit.

Software management accesses have priority. While the software path holds the bus busy, no new poll frame begins. MDC is the system clock divided by a parameter, and it rests low whenever no frame is in flight.

Top module: `mii_autopoll`

## Requirements
- R1: After reset, mdc_o and mdio_oe_o are low, status_o is zero, and link_lost_o, changed_o and irq_o are low.
- R2: A poll frame starts only while both poll_en_i and phy_active_i are high. With either one low, MDC stays idle.
- R3: No poll frame starts while sw_busy_i is high. Once sw_busy_i falls and the gap has already elapsed, the first MDC rise comes within CLK_DIV*3/2 clock cycles.
- R4: A frame is 64 MDC cycles long. The 64 bits, sent MSB-first, are: 32 ones, start 0 then 1, opcode 1 then 0, phy_addr_i[4:0], reg_addr_i[4:0], then 2 turnaround bits and 16 data bits. mdio_oe_o is high for the first 46 bits and low for the last 18. mdio_o is stable at each rising MDC edge.
- R5: The data bits are sampled from mdio_i on the rising MDC edges of bit positions 48 to 63, MSB first. The word appears on status_o once the frame ends.
- R6: MDC has a period of CLK_DIV clock cycles with a 50% duty cycle inside a frame. It is low whenever no frame is running.
- R7: Gap code 0 gives no idle gap. Code n from 1 to 7 gives 2^(n+4) MDC periods, so code 7 gives 2048. Between the last MDC rise of one frame and the first MDC rise of the next, exactly CLK_DIV*(1+gap) clock cycles pass.
- R8: When the gap has already elapsed, for example on the first enable after reset, the first MDC rise comes within CLK_DIV*3/2 clock cycles.
- R9: link_lost_o is set when bit 2 of the new word is 0 and bit 2 of the previous word was 1. The first poll after reset only sets the baseline and raises no flag.
- R10: changed_o is set when the new word differs from the previous word in any bit. A poll that returns the same word leaves both flags unchanged.
- R11: Flags are sticky. irq_clr_i[0] clears link_lost_o and irq_clr_i[1] clears changed_o, with a 0 bit leaving its flag alone. irq_o is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_en_i | input | 1 | Auto-poll enable |
| phy_active_i | input | 1 | A PHY is present and selected |
| sw_busy_i | input | 1 | Software management access owns the bus |
| phy_addr_i | input | 5 | PHY address placed in each frame |
| reg_addr_i | input | 5 | Register address placed in each frame (normally 1) |
| gap_code_i | input | 3 | Idle gap code between frames |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| status_o | output | 16 | Last polled register word |
| link_lost_o | output | 1 | Sticky link-lost flag |
| changed_o | output | 1 | Sticky word-changed flag |
| irq_o | output | 1 | Interrupt request |
| irq_clr_i | input | 2 | Write-1 clear: bit 0 clears link-lost, bit 1 clears changed |

## Verification
The awkward cases sit at frame boundaries. One is the back-to-back restart with code 0, where the next frame begins on the same MDC fall that ends the current one. Another is a frame held off by sw_busy_i after its gap has already run out. The bench models the PHY by watching MDC. It drives read data into the turnaround-free window and times every boundary in clock cycles. It steps through every gap code in rising order, so each long wait follows a short one. It also parks the bus busy across a whole gap before releasing it. The flag logic is then driven with a seeded random mix of repeated words, link-bit toggles, single-bit flips and partial clears.

// File: rtl/mii_ap_pkg.sv
package mii_ap_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned TA_BITS    = 2;
  localparam int unsigned HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int unsigned DATA_FIRST = HDR_BITS + TA_BITS;
  localparam int unsigned FRAME_BITS = DATA_FIRST + DATA_W;
  localparam logic [1:0]  ST_CODE    = 2'b01;
  localparam logic [1:0]  OP_READ    = 2'b10;
  typedef logic [DATA_W-1:0] mii_word_t;
endpackage

// File: rtl/mii_ap_mdc_tick.sv
module mii_ap_mdc_tick #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobes mark MDC half-period boundaries; frames align to fall_o
  assign rise_o = wrap & ~phase_q;
  assign fall_o = wrap & phase_q;
endmodule

// File: rtl/mii_ap_frame.sv
module mii_ap_frame
  import mii_ap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              last_o,
  output logic              done_o,
  output mii_word_t         data_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);

  logic [IDX_W-1:0]    idx_q;
  logic                busy_q, mdc_q, done_q;
  logic [HDR_BITS-1:0] hdr_q, hdr_new;
  mii_word_t           shift_q, data_q;

  assign hdr_new = {{PRE_BITS{1'b1}}, ST_CODE, OP_READ, phy_addr_i, reg_addr_i};
  assign last_o  = busy_q && (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      mdc_q   <= 1'b0;
      done_q  <= 1'b0;
      hdr_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rise_i && busy_q) begin
        mdc_q <= 1'b1;
        if (idx_q >= IDX_W'(DATA_FIRST)) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
      end
      if (fall_i) begin
        mdc_q <= 1'b0;
        if (last_o) begin
          done_q <= 1'b1;
          data_q <= shift_q;
        end
        if (!busy_q || last_o) begin
          // back-to-back restart allowed on the closing edge
          busy_q <= start_i;
          idx_q  <= '0;
          if (start_i) hdr_q <= hdr_new;
        end else begin
          idx_q <= idx_q + 1'b1;
          hdr_q <= {hdr_q[HDR_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign mdc_o     = mdc_q;
  assign mdio_oe_o = busy_q && (idx_q < IDX_W'(HDR_BITS));
  assign mdio_o    = mdio_oe_o & hdr_q[HDR_BITS-1];
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign data_o    = data_q;
endmodule

// File: rtl/mii_ap_timer.sv
module mii_ap_timer
  import mii_ap_pkg::*;
#(
  parameter int unsigned DELAY_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              busy_i,
  input  logic              last_i,
  input  logic              run_i,
  input  logic              sw_busy_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              start_o
);
  localparam int unsigned MAX_EXP = (1 << CODE_W) - 1 + DELAY_SHIFT;
  localparam int unsigned CNT_W   = MAX_EXP + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << MAX_EXP);

  logic [CNT_W-1:0] cnt_q, gap, elapsed;
  logic             slot;

  always_comb begin
    gap = '0;
    if (code_i != '0) gap = CNT_W'(1) << (32'(code_i) + DELAY_SHIFT);
  end

  // closing edge of a frame counts as zero idle periods
  assign slot    = !busy_i || last_i;
  assign elapsed = last_i ? '0 : cnt_q;
  assign start_o = fall_i && slot && run_i && !sw_busy_i && (elapsed >= gap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_MAX;
    end else if (fall_i && slot) begin
      if (start_o)                cnt_q <= '0;
      else if (elapsed == CNT_MAX) cnt_q <= CNT_MAX;
      else                        cnt_q <= elapsed + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mii_ap_status.sv
module mii_ap_status
  import mii_ap_pkg::*;
#(
  parameter int unsigned LINK_BIT = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  mii_word_t data_i,
  input  logic [1:0] clr_i,
  output mii_word_t status_o,
  output logic      link_lost_o,
  output logic      changed_o
);
  mii_word_t prev_q;
  logic      valid_q, lost_q, chg_q;
  logic      set_lost, set_chg;

  assign set_lost = done_i && valid_q && prev_q[LINK_BIT] && !data_i[LINK_BIT];
  assign set_chg  = done_i && valid_q && (data_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
      lost_q  <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      lost_q <= set_lost | (lost_q & ~clr_i[0]);
      chg_q  <= set_chg | (chg_q & ~clr_i[1]);
      if (done_i) begin
        prev_q  <= data_i;
        valid_q <= 1'b1;
      end
    end
  end

  assign status_o    = prev_q;
  assign link_lost_o = lost_q;
  assign changed_o   = chg_q;
endmodule

// File: rtl/mii_autopoll.sv
module mii_autopoll
  import mii_ap_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 8,
  parameter int unsigned DELAY_SHIFT = 4,
  parameter int unsigned LINK_BIT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_en_i,
  input  logic              phy_active_i,
  input  logic              sw_busy_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CODE_W-1:0] gap_code_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] status_o,
  output logic              link_lost_o,
  output logic              changed_o,
  output logic              irq_o,
  input  logic [1:0]        irq_clr_i
);
  logic      rise, fall, start, busy, last, done;
  mii_word_t rd_word;

  mii_ap_mdc_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_o(rise),
    .fall_o(fall)
  );

  mii_ap_timer #(.DELAY_SHIFT(DELAY_SHIFT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .busy_i   (busy),
    .last_i   (last),
    .run_i    (poll_en_i & phy_active_i),
    .sw_busy_i(sw_busy_i),
    .code_i   (gap_code_i),
    .start_o  (start)
  );

  mii_ap_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fall_i    (fall),
    .start_i   (start),
    .phy_addr_i(phy_addr_i),
    .reg_addr_i(reg_addr_i),
    .mdio_i    (mdio_i),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .busy_o    (busy),
    .last_o    (last),
    .done_o    (done),
    .data_o    (rd_word)
  );

  mii_ap_status #(.LINK_BIT(LINK_BIT)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .data_i     (rd_word),
    .clr_i      (irq_clr_i),
    .status_o   (status_o),
    .link_lost_o(link_lost_o),
    .changed_o  (changed_o)
  );

  assign irq_o = link_lost_o | changed_o;
endmodule

// File: rtl/mii_autopoll_chk.sv
module mii_autopoll_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       poll_en_i,
  input logic       phy_active_i,
  input logic       sw_busy_i,
  input logic [1:0] irq_clr_i,
  input logic       mdc_o,
  input logic       mdio_oe_o,
  input logic       link_lost_o,
  input logic       changed_o,
  input logic       busy_i,
  input logic       done_i
);
  p_start_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(poll_en_i && phy_active_i));

  p_start_sw_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(sw_busy_i));

  p_oe_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy_i);

  p_mdc_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_o);

  p_lost_after_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_lost_o) |-> $past(done_i));

  p_chg_after_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(changed_o) |-> $past(done_i));

  p_lost_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_lost_o && !irq_clr_i[0]) |=> link_lost_o);

  p_lost_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i[0] && !done_i) |=> !link_lost_o);

  p_chg_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i[1] && !done_i) |=> !changed_o);
endmodule

bind mii_autopoll mii_autopoll_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .poll_en_i   (poll_en_i),
  .phy_active_i(phy_active_i),
  .sw_busy_i   (sw_busy_i),
  .irq_clr_i   (irq_clr_i),
  .mdc_o       (mdc_o),
  .mdio_oe_o   (mdio_oe_o),
  .link_lost_o (link_lost_o),
  .changed_o   (changed_o),
  .busy_i      (busy),
  .done_i      (done)
);

// File: tb/tb_mii_autopoll.sv
module tb_mii_autopoll;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_en = 1'b0, phy_active = 1'b0, sw_busy = 1'b0;
  logic [4:0]  phy_addr = 5'h13, reg_addr = 5'h01;
  logic [2:0]  gap_code = 3'd0;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, link_lost, changed, irq;
  logic [15:0] status;
  logic [1:0]  irq_clr = 2'b00;

  always #10 clk = ~clk;

  mii_autopoll #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_en_i(poll_en), .phy_active_i(phy_active),
    .sw_busy_i(sw_busy), .phy_addr_i(phy_addr), .reg_addr_i(reg_addr),
    .gap_code_i(gap_code), .mdio_i(mdio_i), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .status_o(status), .link_lost_o(link_lost),
    .changed_o(changed), .irq_o(irq), .irq_clr_i(irq_clr)
  );

  int total = 0, bad = 0;
  int unsigned cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // PHY model and frame monitor
  logic [15:0] phy_word = 16'h0000, cur_word = 16'h0000;
  logic [45:0] hdr_exp;
  logic [15:0] m_prev = 16'h0;
  bit          m_valid = 0, m_lost = 0, m_chg = 0;
  int          rise_cnt = 0, frames = 0, hdr_err = 0, per_err = 0;
  int unsigned rise_t = 0, prev_rise_t = 0, first_rise_t = 0, last_rise_t = 0;
  event        ev_start, ev_end;

  function automatic int exp_gap(input logic [2:0] c);
    return (c == 3'd0) ? 0 : (1 << (int'(c) + 4));
  endfunction

  initial begin
    forever begin
      @(posedge mdc);
      prev_rise_t = rise_t;
      rise_t = cyc;
      if (rise_cnt == 0) begin
        cur_word = phy_word;
        first_rise_t = rise_t;
        hdr_err = 0;
        per_err = 0;
        ->ev_start;
      end else if (rise_t - prev_rise_t != DIV) begin
        per_err++;
      end
      if (rise_cnt < 46) begin
        if (!mdio_oe || mdio_o !== hdr_exp[45 - rise_cnt]) hdr_err++;
      end else if (mdio_oe) begin
        hdr_err++;
      end
      rise_cnt++;
      @(negedge mdc);
      if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = cur_word[15 - (rise_cnt - 48)];
      else mdio_i = 1'b1;
      if (rise_cnt == 64) begin
        last_rise_t = rise_t;
        rise_cnt = 0;
        frames++;
        @(negedge clk);
        @(negedge clk);
        if (m_valid) begin
          if (m_prev[2] && !cur_word[2]) m_lost = 1;
          if (cur_word != m_prev) m_chg = 1;
        end
        m_prev = cur_word;
        m_valid = 1;
        chk(hdr_err == 0, "R4 header/oe", hdr_err, 0);
        chk(per_err == 0, "R6 mdc period", per_err, 0);
        chk(status == cur_word, "R5 status word", int'(status), int'(cur_word));
        chk(link_lost == m_lost, "R9 link_lost", int'(link_lost), int'(m_lost));
        chk(changed == m_chg, "R10 changed", int'(changed), int'(m_chg));
        chk(irq == (m_lost | m_chg), "R11 irq", int'(irq), int'(m_lost | m_chg));
        ->ev_end;
      end
    end
  end

  task automatic clear(input logic [1:0] c);
    @(negedge clk);
    irq_clr = c;
    if (c[0]) m_lost = 0;
    if (c[1]) m_chg = 0;
    @(negedge clk);
    irq_clr = 2'b00;
    @(negedge clk);
    chk(link_lost == m_lost && changed == m_chg, "R11 clear",
        int'({link_lost, changed}), int'({m_lost, m_chg}));
    chk(irq == (m_lost | m_chg), "R11 irq after clear", int'(irq), int'(m_lost | m_chg));
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", frames, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned t0;
    int          fr0;
    void'($urandom(32'd4242));
    hdr_exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, reg_addr};
    repeat (5) @(negedge clk);
    // R1 reset values
    chk(mdc == 0 && mdio_oe == 0, "R1 pins", int'({mdc, mdio_oe}), 0);
    chk(status == 16'h0 && !link_lost && !changed && !irq, "R1 flags",
        int'({status, link_lost, changed, irq}), 0);
    rst_n = 1'b1;

    // R2: disabled or inactive PHY keeps bus idle
    phy_active = 1'b1;
    repeat (300) @(negedge clk);
    chk(frames == 0 && rise_cnt == 0 && !mdc, "R2 poll_en low", rise_cnt, 0);
    poll_en = 1'b1;
    phy_active = 1'b0;
    repeat (300) @(negedge clk);
    chk(frames == 0 && rise_cnt == 0 && !mdc, "R2 phy inactive", rise_cnt, 0);

    // R8: first poll starts promptly
    phy_word = 16'h786D;
    phy_active = 1'b1;
    t0 = cyc;
    @ev_start;
    chk(first_rise_t - t0 <= DIV + HALF, "R8 first start", int'(first_rise_t - t0), DIV + HALF);
    @ev_end;
    chk(!link_lost && !changed, "R9 baseline no flag", int'({link_lost, changed}), 0);
    @ev_end;
    chk(!changed, "R10 same word", int'(changed), 0);
    phy_word = 16'h7869;
    @ev_end;
    chk(link_lost && changed, "R9 link drop", int'({link_lost, changed}), 3);
    clear(2'b01);
    phy_word = 16'h786D;
    @ev_end;
    chk(!link_lost && changed, "R9 link rise no lost", int'({link_lost, changed}), 1);
    clear(2'b10);

    // R7: every gap code
    for (int c = 0; c < 8; c++) begin
      gap_code = 3'(c);
      @ev_end;
      t0 = last_rise_t;
      @ev_start;
      chk(first_rise_t - t0 == DIV * (1 + exp_gap(3'(c))), "R7 gap",
          int'(first_rise_t - t0), DIV * (1 + exp_gap(3'(c))));
    end

    // R3: software owns the bus through and past the gap
    gap_code = 3'd3;
    @ev_end;
    sw_busy = 1'b1;
    fr0 = frames;
    repeat (1500) @(negedge clk);
    chk(frames == fr0 && rise_cnt == 0 && !mdc, "R3 held off", frames - fr0, 0);
    t0 = cyc;
    sw_busy = 1'b0;
    @ev_start;
    chk(first_rise_t - t0 <= DIV + HALF, "R3 release start", int'(first_rise_t - t0), DIV + HALF);

    // random mix on flags R9 R10 R11
    gap_code = 3'd0;
    for (int i = 0; i < 30; i++) begin
      @ev_end;
      case ($urandom % 4)
        0: phy_word = phy_word;
        1: phy_word = phy_word ^ 16'h0004;
        2: phy_word = 16'($urandom);
        default: phy_word = phy_word ^ (16'h1 << ($urandom % 16));
      endcase
      if ($urandom % 3 == 0) clear(2'($urandom % 4));
    end
    @ev_end;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule